// File: doc/BRIEF.md
# Selectable-Polynomial CRC-32 Accumulate Unit

This unit folds up to eight data bytes into a running 32-bit CRC value. A single request supplies the current accumulator, a 64-bit data word, a size code that picks 1, 2, 4 or 8 bytes, and a polynomial choice: the IEEE CRC-32 or the Castagnoli CRC-32C. The bytes are taken from the least significant end of the data word. The unit returns the updated accumulator together with a one-cycle completion flag.

The unit neither inverts the accumulator on entry nor inverts the result on exit. Software that needs the usual pre-set and final complement applies them on its side, so the output is the raw reflected CRC update. A build parameter picks one of two engines. The serial engine costs one byte-step of logic and takes one clock per byte. The parallel engine chains all eight byte-steps and answers one clock after the request.

Top module: `crc_accum`

## Requirements
- R1: After reset, `done` and `busy` are 0 and `crc_out` is 0.
- R2: `size_sel` gives the byte count as 0→1, 1→2, 2→4, 3→8. Bytes are consumed starting at `data_in[7:0]` and moving upward, one byte at a time.
- R3: With `poly_sel`=0 the update is the bit-reflected CRC-32 with reversed polynomial 0xEDB88320. Accumulator 0 with the single byte 0x01 gives 0x77073096.
- R4: With `poly_sel`=1 the update is the bit-reflected CRC-32C with reversed polynomial 0x82F63B78. Accumulator 0 with the single byte 0x80 gives 0x82F63B78, and with the single byte 0x01 it gives 0xF26B8303.
- R5: No complement is applied on entry or on exit. Accumulator 0 with all-zero data gives 0 for any size.
- R6: In the serial engine (`SERIAL`=1), an accepted start raises `busy` on the next clock. One byte is then processed per clock. `done` is seen on the clock after the last byte, which is N+1 clocks after the start edge counts its first, and `busy` is low while `done` is high.
- R7: In the parallel engine (`SERIAL`=0), `done` and the result appear on the clock after the start, whatever the size.
- R8: `done` is a one-cycle pulse. `crc_out` changes only at a completion and holds its value until the next completion.
- R9: A start while `busy` is high is ignored. The running operation completes with its original operands and timing.
- R10: Data bytes above the selected count have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request strobe, one cycle |
| poly_sel | input | 1 | 0 = CRC-32, 1 = CRC-32C |
| size_sel | input | 2 | Byte count code (1, 2, 4, 8 bytes) |
| acc_in | input | 32 | Accumulator to update |
| data_in | input | 64 | Data bytes, least significant first |
| busy | output | 1 | Serial engine is working through bytes |
| done | output | 1 | One-cycle completion pulse |
| crc_out | output | 32 | Updated accumulator, held between completions |

## Verification
The hardest case to reach is a new start arriving while the serial engine is partway through an eight-byte update. A stale or corrupted operand latch would only show up then. The bench raises a second strobe the cycle after an accepted one, with different data and polynomial on the inputs. It then checks that the result and the completion time still match the first request. Junk bytes above the selected count are also driven, to show that they leave the result unchanged.

// File: rtl/crc_accum_pkg.sv
package crc_accum_pkg;
   localparam logic [31:0] POLY_IEEE_REFL = 32'hEDB88320;
   localparam logic [31:0] POLY_CAST_REFL = 32'h82F63B78;

   typedef enum logic {
      POLY_IEEE = 1'b0,
      POLY_CAST = 1'b1
   } poly_e;
endpackage

// File: rtl/crc_byte_step.sv
module crc_byte_step #(
   parameter int          CRC_W  = 32,
   parameter logic [31:0] POLY_A = 32'hEDB88320,
   parameter logic [31:0] POLY_B = 32'h82F63B78
) (
   input  logic [CRC_W-1:0] crc_i,
   input  logic [7:0]       byte_i,
   input  logic             poly_sel,
   output logic [CRC_W-1:0] crc_o
);
   localparam int BITS = 8;

   logic [CRC_W-1:0] poly;
   logic [CRC_W-1:0] bit_st [BITS+1];

   assign poly      = (poly_sel == crc_accum_pkg::POLY_CAST) ? POLY_B[CRC_W-1:0] : POLY_A[CRC_W-1:0];
   assign bit_st[0] = crc_i ^ {{(CRC_W-BITS){1'b0}}, byte_i};

   generate
      for (genvar b = 0; b < BITS; b++) begin : g_bit
         assign bit_st[b+1] = (bit_st[b] >> 1) ^ (bit_st[b][0] ? poly : '0);
      end
   endgenerate

   assign crc_o = bit_st[BITS];
endmodule

// File: rtl/crc_serial_engine.sv
module crc_serial_engine #(
   parameter int          CRC_W  = 32,
   parameter int          DATA_W = 64,
   parameter int          SEL_W  = 2,
   parameter logic [31:0] POLY_A = 32'hEDB88320,
   parameter logic [31:0] POLY_B = 32'h82F63B78
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              poly_sel,
   input  logic [SEL_W-1:0]  size_sel,
   input  logic [CRC_W-1:0]  acc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              busy,
   output logic              done,
   output logic [CRC_W-1:0]  crc_out
);
   localparam int NBYTES = DATA_W / 8;
   localparam int CNT_W  = $clog2(NBYTES) + 1;

   logic              busy_q, done_q, poly_q;
   logic [CNT_W-1:0]  left_q;
   logic [CRC_W-1:0]  work_q, res_q, step_crc;
   logic [DATA_W-1:0] data_q;

   crc_byte_step #(.CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_step (
      .crc_i    (work_q),
      .byte_i   (data_q[7:0]),
      .poly_sel (poly_q),
      .crc_o    (step_crc)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         poly_q <= 1'b0;
         left_q <= '0;
         work_q <= '0;
         res_q  <= '0;
         data_q <= '0;
      end else begin
         done_q <= 1'b0;
         if (busy_q) begin
            work_q <= step_crc;
            data_q <= data_q >> 8;
            left_q <= left_q - 1'b1;
            if (left_q == CNT_W'(1)) begin
               busy_q <= 1'b0;
               done_q <= 1'b1;
               res_q  <= step_crc;
            end
         end else if (start) begin
            busy_q <= 1'b1;
            poly_q <= poly_sel;
            work_q <= acc_in;
            data_q <= data_in;
            left_q <= CNT_W'(1 << size_sel);
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign crc_out = res_q;

   AST_DONE_PULSE:  assert property (@(posedge clk) disable iff (!rst_n) done_q |=> !done_q); // R8
   AST_DONE_IDLE:   assert property (@(posedge clk) disable iff (!rst_n) done_q |-> !busy_q); // R6
   AST_BYTE_STEP:   assert property (@(posedge clk) disable iff (!rst_n)
                       (busy_q && left_q > CNT_W'(1)) |=> (busy_q && left_q == $past(left_q) - 1'b1)); // R6
   AST_START_BUSY:  assert property (@(posedge clk) disable iff (!rst_n) (start && !busy_q) |=> busy_q); // R6
   AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
                       (busy_q && start) |=> (poly_q == $past(poly_q))); // R9
   AST_RES_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !done_q |-> $stable(res_q)); // R8
endmodule

// File: rtl/crc_parallel_engine.sv
module crc_parallel_engine #(
   parameter int          CRC_W  = 32,
   parameter int          DATA_W = 64,
   parameter int          SEL_W  = 2,
   parameter logic [31:0] POLY_A = 32'hEDB88320,
   parameter logic [31:0] POLY_B = 32'h82F63B78
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              poly_sel,
   input  logic [SEL_W-1:0]  size_sel,
   input  logic [CRC_W-1:0]  acc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              busy,
   output logic              done,
   output logic [CRC_W-1:0]  crc_out
);
   localparam int NBYTES = DATA_W / 8;
   localparam int SEL_N  = $clog2(NBYTES) + 1;

   logic [CRC_W-1:0] stage [NBYTES+1];
   logic [CRC_W-1:0] pick;
   logic             done_q;
   logic [CRC_W-1:0] res_q;

   assign stage[0] = acc_in;

   generate
      for (genvar k = 0; k < NBYTES; k++) begin : g_byte
         crc_byte_step #(.CRC_W(CRC_W), .POLY_A(POLY_A), .POLY_B(POLY_B)) u_step (
            .crc_i    (stage[k]),
            .byte_i   (data_in[8*k +: 8]),
            .poly_sel (poly_sel),
            .crc_o    (stage[k+1])
         );
      end
   endgenerate

   always_comb begin
      pick = stage[1];
      for (int k = 0; k < SEL_N; k++) begin
         if (size_sel == SEL_W'(k)) pick = stage[1 << k];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
         res_q  <= '0;
      end else begin
         done_q <= start;
         if (start) res_q <= pick;
      end
   end

   assign busy    = 1'b0;
   assign done    = done_q;
   assign crc_out = res_q;

   AST_PAR_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) start |=> done_q); // R7
   AST_PAR_HOLD:    assert property (@(posedge clk) disable iff (!rst_n) !done_q |-> $stable(res_q)); // R8
endmodule

// File: rtl/crc_accum.sv
module crc_accum #(
   parameter int          CRC_W  = 32,
   parameter int          DATA_W = 64,
   parameter bit          SERIAL = 1'b1,
   parameter logic [31:0] POLY_A = crc_accum_pkg::POLY_IEEE_REFL,
   parameter logic [31:0] POLY_B = crc_accum_pkg::POLY_CAST_REFL,
   localparam int         SEL_W  = $clog2($clog2(DATA_W / 8) + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              poly_sel,
   input  logic [SEL_W-1:0]  size_sel,
   input  logic [CRC_W-1:0]  acc_in,
   input  logic [DATA_W-1:0] data_in,
   output logic              busy,
   output logic              done,
   output logic [CRC_W-1:0]  crc_out
);
   generate
      if (CRC_W != 32) begin : g_bad_crc
         $error("crc_accum: CRC_W must be 32");
      end
      if (DATA_W % 8 != 0 || DATA_W < 16 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("crc_accum: DATA_W must be a power of two multiple of 8");
      end

      if (SERIAL) begin : g_serial
         crc_serial_engine #(.CRC_W(CRC_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
                             .POLY_A(POLY_A), .POLY_B(POLY_B)) u_eng (
            .clk, .rst_n, .start, .poly_sel, .size_sel, .acc_in, .data_in,
            .busy, .done, .crc_out
         );
      end else begin : g_parallel
         crc_parallel_engine #(.CRC_W(CRC_W), .DATA_W(DATA_W), .SEL_W(SEL_W),
                               .POLY_A(POLY_A), .POLY_B(POLY_B)) u_eng (
            .clk, .rst_n, .start, .poly_sel, .size_sel, .acc_in, .data_in,
            .busy, .done, .crc_out
         );
      end
   endgenerate

   AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                    (!done && !$rose(done)) |-> $stable(crc_out)); // R8
endmodule

// File: tb/crc_accum_test.sv
module crc_accum_test;
   typedef struct packed {
      logic [31:0] acc;
      logic [63:0] data;
      logic [1:0]  sel;
      logic        poly;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VEC [NV] = '{
      '{32'h00000000, 64'h0000000000000001, 2'd0, 1'b0},
      '{32'h00000000, 64'h0000000000000080, 2'd0, 1'b1},
      '{32'hFFFFFFFF, 64'h0000000000003231, 2'd1, 1'b0},
      '{32'h12345678, 64'h00000000DEADBEEF, 2'd2, 1'b1},
      '{32'hFFFFFFFF, 64'h0123456789ABCDEF, 2'd3, 1'b0},
      '{32'h00000000, 64'h0000000000000000, 2'd3, 1'b1},
      '{32'hA5A5A5A5, 64'h00000000FEDCBA98, 2'd2, 1'b0},
      '{32'hC0FFEE11, 64'h8877665544332211, 2'd3, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        s_start = 1'b0, p_start = 1'b0;
   logic        poly_sel = 1'b0;
   logic [1:0]  size_sel = 2'd0;
   logic [31:0] acc_in = '0;
   logic [63:0] data_in = '0;
   logic        s_busy, s_done, p_busy, p_done;
   logic [31:0] s_crc, p_crc;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   int          s_lat, p_lat;
   logic [31:0] s_res, p_res;

   always #5 clk = ~clk;

   crc_accum uut (
      .clk, .rst_n, .start(s_start), .poly_sel, .size_sel, .acc_in, .data_in,
      .busy(s_busy), .done(s_done), .crc_out(s_crc)
   );

   crc_accum #(.SERIAL(1'b0)) uut_par (
      .clk, .rst_n, .start(p_start), .poly_sel, .size_sel, .acc_in, .data_in,
      .busy(p_busy), .done(p_done), .crc_out(p_crc)
   );

   function automatic logic [31:0] ref_crc(logic [31:0] acc, logic [63:0] data,
                                           int nbytes, logic poly);
      logic [31:0] c = acc;
      logic [31:0] p = poly ? 32'h82F63B78 : 32'hEDB88320;
      for (int i = 0; i < nbytes; i++) begin
         for (int b = 0; b < 8; b++) begin
            if (c[0] ^ data[8*i+b]) c = (c >> 1) ^ p;
            else                    c = c >> 1;
         end
      end
      return c;
   endfunction

   task automatic check(string req, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Issue one request; poke raises a second serial strobe one cycle later.
   task automatic run_op(logic [31:0] acc, logic [63:0] data, logic [1:0] sel,
                         logic poly, bit use_p, bit poke);
      s_lat = 0; p_lat = 0; s_res = '0; p_res = '0;
      @(negedge clk);
      acc_in = acc; data_in = data; size_sel = sel; poly_sel = poly;
      s_start = 1'b1; p_start = use_p;
      @(negedge clk);
      s_start = 1'b0; p_start = 1'b0;
      for (int i = 1; i <= 20; i++) begin
         if (poke && i == 1) begin
            check("R9 busy at poke", {63'd0, s_busy}, 64'd1);
            s_start = 1'b1; data_in = ~data; poly_sel = ~poly; acc_in = ~acc;
         end else begin
            s_start = 1'b0;
         end
         if (s_done && s_lat == 0) begin s_lat = i; s_res = s_crc; end
         if (p_done && p_lat == 0) begin p_lat = i; p_res = p_crc; end
         if (s_lat != 0 && (p_lat != 0 || !use_p)) break;
         @(negedge clk);
      end
      s_start = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!finished) begin
         errors++; checks++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 serial done", {63'd0, s_done}, 64'd0);
      check("R1 serial busy", {63'd0, s_busy}, 64'd0);
      check("R1 serial crc", {32'd0, s_crc}, 64'd0);
      check("R1 parallel crc", {32'd0, p_crc}, 64'd0);
      rst_n = 1'b1;

      // Vector table: R2 size/order, R3/R4 polynomials, R6/R7 timing
      for (int v = 0; v < NV; v++) begin
         automatic int n = 1 << VEC[v].sel;
         automatic logic [31:0] e = ref_crc(VEC[v].acc, VEC[v].data, n, VEC[v].poly);
         run_op(VEC[v].acc, VEC[v].data, VEC[v].sel, VEC[v].poly, 1'b1, 1'b0);
         check(VEC[v].poly ? "R4 serial crc" : "R3 serial crc", {32'd0, s_res}, {32'd0, e});
         check(VEC[v].poly ? "R4 parallel crc" : "R3 parallel crc", {32'd0, p_res}, {32'd0, e});
         check("R6 serial latency", 64'(s_lat), 64'(n + 1));
         check("R7 parallel latency", 64'(p_lat), 64'd1);
         check("R2 size select", {32'd0, s_res}, {32'd0, ref_crc(VEC[v].acc, VEC[v].data, n, VEC[v].poly)});
         @(negedge clk);
         check("R8 done pulse serial", {63'd0, s_done}, 64'd0);
         check("R8 done pulse parallel", {63'd0, p_done}, 64'd0);
         check("R8 serial hold", {32'd0, s_crc}, {32'd0, e});
      end

      // Known constants
      run_op(32'h0, 64'h01, 2'd0, 1'b0, 1'b1, 1'b0);
      check("R3 known byte", {32'd0, s_res}, 64'h77073096);
      run_op(32'h0, 64'h80, 2'd0, 1'b1, 1'b1, 1'b0);
      check("R4 known byte 0x80", {32'd0, p_res}, 64'h82F63B78);
      run_op(32'h0, 64'h01, 2'd0, 1'b1, 1'b1, 1'b0);
      check("R4 known byte 0x01", {32'd0, s_res}, 64'hF26B8303);

      // R5 no inversion
      run_op(32'h0, 64'h0, 2'd2, 1'b0, 1'b1, 1'b0);
      check("R5 zero in zero out serial", {32'd0, s_res}, 64'd0);
      check("R5 zero in zero out parallel", {32'd0, p_res}, 64'd0);

      // R2 little-endian order: 0x0001 vs 0x0100 over two bytes
      run_op(32'h0, 64'h0100, 2'd1, 1'b0, 1'b1, 1'b0);
      check("R2 byte order", {32'd0, s_res}, {32'd0, ref_crc(32'h0, 64'h0100, 2, 1'b0)});
      check("R2 byte order differs", {63'd0, s_res == 32'h77073096}, 64'd1);

      // R10 junk above count
      run_op(32'h89ABCDEF, 64'hFFEEDDCC_00005A3C, 2'd1, 1'b1, 1'b1, 1'b0);
      check("R10 serial upper ignored", {32'd0, s_res},
            {32'd0, ref_crc(32'h89ABCDEF, 64'h5A3C, 2, 1'b1)});
      check("R10 parallel upper ignored", {32'd0, p_res},
            {32'd0, ref_crc(32'h89ABCDEF, 64'h5A3C, 2, 1'b1)});

      // R9 start while busy on an 8-byte serial run
      run_op(32'h13579BDF, 64'h0F1E2D3C4B5A6978, 2'd3, 1'b0, 1'b0, 1'b1);
      check("R9 result unchanged", {32'd0, s_res},
            {32'd0, ref_crc(32'h13579BDF, 64'h0F1E2D3C4B5A6978, 8, 1'b0)});
      check("R9 latency unchanged", 64'(s_lat), 64'd9);
      @(negedge clk);
      check("R9 no second run", {63'd0, s_busy}, 64'd0);
      check("R8 hold after poke", {32'd0, s_crc},
            {32'd0, ref_crc(32'h13579BDF, 64'h0F1E2D3C4B5A6978, 8, 1'b0)});

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule